// File: doc/BRIEF.md
# Programmable Periodic Interval Timer

This block raises a periodic interrupt at a rate chosen by software. A prescaler divides the system clock down to a one-millisecond enable pulse. A period counter counts those pulses against a 9-bit reload value, so one period lasts (reload + 1) milliseconds. That is a tick rate of 1000/(reload + 1) Hz.

At the end of each period the interrupt output is set, and the next period starts at once. The interrupt stays high until it is acknowledged, either by a dedicated acknowledge strobe or, when the parameter enables it, by a read strobe.

A write to the reload register has three effects:
- It keeps only the low bits of the bus data.
- It drops any pending interrupt.
- It restarts both the prescaler and the period counter from that clock edge.

Top module: `pit_timer`

## Requirements
- R1: A write stores only the low RLD_W (default 9) bits of `wr_data` (the value AND 0x1FF). The stored value is visible on `rd_data` from the cycle after the write.
- R2: After a write of value V on clock edge E, `irq` first goes high on edge E + CYC_PER_MS*(V+1).
- R3: In the cycle after a write, `irq` is low, even if it was high before.
- R4: A write in the middle of a period discards the elapsed time. The next expiry is measured from the new write only.
- R5: Without further writes, expiries repeat every CYC_PER_MS*(V+1) cycles, whether or not the interrupt was acknowledged in between.
- R6: Once set, `irq` stays high across later cycles and expiries until it is cleared by an acknowledge, a read (R8) or a write.
- R7: A one-cycle `ack` pulse clears `irq` on the following edge.
- R8: With ACK_ON_READ=1, a one-cycle `rd_en` pulse clears `irq` on the following edge. `rd_data` always shows the reload value.
- R9: After reset, the reload value is 0 and `irq` is low. The first expiry comes CYC_PER_MS cycles after reset is released.
- R10: When a write lands on the same edge as an expiry, the write wins: `irq` stays low and a new period starts.
- R11: When `ack` lands on the same edge as an expiry, the expiry wins: `irq` is high after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Reload write strobe |
| wr_data | input | BUS_W | Write data; only the low RLD_W bits are kept |
| rd_en | input | 1 | Read strobe; also clears the interrupt when ACK_ON_READ=1 |
| ack | input | 1 | Interrupt acknowledge strobe |
| rd_data | output | RLD_W | Current reload value |
| irq | output | 1 | Periodic interrupt, held until cleared |

## Verification
The hardest cases to reach are the ones where a strobe and an internal expiry fall on the same clock edge. No port exposes the prescaler or the period counter.

The bench therefore counts cycles from the last write. It uses the arithmetic period CYC_PER_MS*(V+1) to place a write, or an acknowledge, exactly on the expiry edge. This shows which of the two wins.

With a small prescale factor, a sweep over many reload values also checks both the first period and the repeat period.

// File: rtl/pit_pkg.sv
package pit_pkg;
   typedef enum logic [1:0] {
      IRQ_KEEP = 2'd0,
      IRQ_SET  = 2'd1,
      IRQ_DROP = 2'd2
   } irq_op_e;
endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
   parameter int CYC_PER_MS = 50000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic tick
);
   localparam int CW = (CYC_PER_MS > 2) ? $clog2(CYC_PER_MS) : 1;
   localparam logic [CW-1:0] LAST = CW'(CYC_PER_MS - 1);

   logic [CW-1:0] cnt_q;

   assign tick = (cnt_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n)        cnt_q <= '0;
      else if (restart)  cnt_q <= '0;
      else if (tick)     cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/pit_period.sv
module pit_period #(
   parameter int RLD_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [RLD_W-1:0] load_val,
   input  logic             ms_tick,
   output logic [RLD_W-1:0] reload,
   output logic             expire
);
   logic [RLD_W-1:0] reload_q;
   logic [RLD_W-1:0] ms_cnt_q;

   assign reload = reload_q;
   assign expire = ms_tick && (ms_cnt_q == reload_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reload_q <= '0;
         ms_cnt_q <= '0;
      end else if (load) begin
         reload_q <= load_val;
         ms_cnt_q <= '0;
      end else if (expire) begin
         ms_cnt_q <= '0;
      end else if (ms_tick) begin
         ms_cnt_q <= ms_cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/pit_irq.sv
module pit_irq #(
   parameter bit ACK_ON_READ = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic expire,
   input  logic ack,
   input  logic rd_en,
   output logic irq
);
   import pit_pkg::*;

   logic    clr;
   irq_op_e op;
   logic    irq_q;

   generate
      if (ACK_ON_READ) begin : g_rd_clears
         assign clr = ack | rd_en;
      end else begin : g_ack_only
         logic unused_rd;
         assign unused_rd = rd_en;
         assign clr = ack;
      end
   endgenerate

   always_comb begin
      if (restart)     op = IRQ_DROP;
      else if (expire) op = IRQ_SET;
      else if (clr)    op = IRQ_DROP;
      else             op = IRQ_KEEP;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) irq_q <= 1'b0;
      else begin
         case (op)
            IRQ_SET:  irq_q <= 1'b1;
            IRQ_DROP: irq_q <= 1'b0;
            default:  irq_q <= irq_q;
         endcase
      end
   end

   assign irq = irq_q;
endmodule

// File: rtl/pit_timer.sv
module pit_timer #(
   parameter int CYC_PER_MS  = 50000,
   parameter int RLD_W       = 9,
   parameter int BUS_W       = 32,
   parameter bit ACK_ON_READ = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [BUS_W-1:0] wr_data,
   input  logic             rd_en,
   input  logic             ack,
   output logic [RLD_W-1:0] rd_data,
   output logic             irq
);
   generate
      if (CYC_PER_MS < 2) begin : g_bad_prescale
         $error("pit_timer: CYC_PER_MS must be at least 2");
      end
      if (RLD_W < 1 || BUS_W <= RLD_W) begin : g_bad_width
         $error("pit_timer: need 1 <= RLD_W < BUS_W");
      end
   endgenerate

   logic ms_tick;
   logic period_end;
   logic unused_hi;

   assign unused_hi = ^wr_data[BUS_W-1:RLD_W];

   pit_prescaler #(.CYC_PER_MS(CYC_PER_MS)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (wr_en),
      .tick    (ms_tick)
   );

   pit_period #(.RLD_W(RLD_W)) u_per (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wr_en),
      .load_val (wr_data[RLD_W-1:0]),
      .ms_tick  (ms_tick),
      .reload   (rd_data),
      .expire   (period_end)
   );

   pit_irq #(.ACK_ON_READ(ACK_ON_READ)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (wr_en),
      .expire  (period_end),
      .ack     (ack),
      .rd_en   (rd_en),
      .irq     (irq)
   );
endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk #(
   parameter int CYC_PER_MS = 50000,
   parameter int RLD_W      = 9,
   parameter int BUS_W      = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [BUS_W-1:0] wr_data,
   input logic             rd_en,
   input logic             ack,
   input logic [RLD_W-1:0] rd_data,
   input logic             irq,
   input logic             ms_tick,
   input logic             period_end
);
   int unsigned gap_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                gap_q <= 0;
      else if (ms_tick || wr_en) gap_q <= 0;
      else                       gap_q <= gap_q + 1;
   end

   AST_RELOAD_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> rd_data == $past(wr_data[RLD_W-1:0]));                       // R1
   AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(ms_tick));                                        // R2
   AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      gap_q < CYC_PER_MS);                                                   // R5
   AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !irq);                                                       // R3
   AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      irq && !ack && !rd_en && !wr_en |=> irq);                              // R6
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      ack && !wr_en && !period_end |=> !irq);                                // R7
   AST_EXPIRY_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      period_end && !wr_en |=> irq);                                         // R11
endmodule

bind pit_timer pit_timer_chk #(
   .CYC_PER_MS (CYC_PER_MS),
   .RLD_W      (RLD_W),
   .BUS_W      (BUS_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_data    (wr_data),
   .rd_en      (rd_en),
   .ack        (ack),
   .rd_data    (rd_data),
   .irq        (irq),
   .ms_tick    (ms_tick),
   .period_end (period_end)
);

// File: tb/sim_pit_timer.sv
`timescale 1ns/1ps
module sim_pit_timer;
   localparam int C = 4;

   int n_chk = 0;
   int n_bad = 0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic        ack = 1'b0;
   logic [8:0]  rd_data;
   logic        irq;

   always #2.5 clk = ~clk;

   pit_timer #(.CYC_PER_MS(C), .RLD_W(9), .BUS_W(32), .ACK_ON_READ(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .ack(ack), .rd_data(rd_data), .irq(irq)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic wr(input logic [31:0] d);
      wr_en = 1'b1; wr_data = d;
      step();
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic wait_rise(output int n);
      n = 0;
      while (!irq && n < 5000) begin
         step();
         n++;
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
   endtask

   initial begin
      #900000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      summary();
      $finish;
   end

   initial begin
      int n;
      int t;
      step(); step(); step();
      rst_n = 1'b1;
      // R9: reset state and first period
      check(rd_data == 0, "R9 reload", rd_data, 0);
      check(irq == 0, "R9 irq", irq, 0);
      wait_rise(n);
      check(n == C, "R9 first expiry", n, C);

      // R2 / R3 / R7 / R5: sweep of reload values
      for (int r = 0; r < 52; r++) begin
         int v;
         int p;
         v = (r < 48) ? r : (r == 48 ? 255 : (r == 49 ? 511 : (r == 50 ? 100 : 300)));
         p = C * (v + 1);
         wr(32'(v));
         check(irq == 0, "R3 write clears", irq, 0);
         wait_rise(n);
         check(n == p, "R2 first period", n, p);
         t = n;
         ack = 1'b1; step(); t++; ack = 1'b0;
         check(irq == 0, "R7 ack clears", irq, 0);
         while (!irq && t < 5000) begin step(); t++; end
         check(t == 2 * p, "R5 repeat period", t, 2 * p);
      end

      // R1: masking of upper bits
      wr(32'hFFFF_FE05);
      check(rd_data == 5, "R1 mask", rd_data, 5);
      wait_rise(n);
      check(n == 24, "R1 masked period", n, 24);

      // R6: held over several later expiries
      begin
         bit stayed;
         stayed = 1'b1;
         for (int k = 0; k < 72; k++) begin
            step();
            if (!irq) stayed = 1'b0;
         end
         check(stayed, "R6 hold", int'(stayed), 1);
      end

      // R8: read strobe clears
      rd_en = 1'b1; step(); rd_en = 1'b0;
      check(irq == 0, "R8 read clears", irq, 0);
      check(rd_data == 5, "R8 readback", rd_data, 5);

      // R4: mid-period rewrite restarts
      wr(32'd3);
      for (int k = 0; k < 5; k++) step();
      wr(32'd3);
      wait_rise(n);
      check(n == 16, "R4 restart", n, 16);

      // R10: write on the expiry edge
      wr(32'd2);
      for (int k = 0; k < 11; k++) step();
      wr(32'd1);
      check(irq == 0, "R10 write wins", irq, 0);
      wait_rise(n);
      check(n == 8, "R10 new period", n, 8);

      // R11: ack on the expiry edge
      wr(32'd0);
      wait_rise(n);
      check(n == 4, "R11 setup", n, 4);
      ack = 1'b1; step(); ack = 1'b0;
      check(irq == 0, "R11 cleared", irq, 0);
      step(); step();
      ack = 1'b1; step(); ack = 1'b0;
      check(irq == 1, "R11 expiry wins", irq, 1);

      summary();
      $finish;
   end
endmodule